// File: doc/BRIEF.md
# Mixed-Page-Size Translation Buffer with Rotating Replacement

This block is a fully associative translation cache for a 32-bit address space. Each of its slots holds one mapping. The mapping can cover a 1 MB section, a 64 KB large page or a 4 KB small page, and every slot compares only as many upper address bits as its own page size needs. A combinational lookup port takes a virtual address. It returns a hit flag, the translated physical address and the attribute bits stored with the mapping: cacheable, bufferable and a two-bit access permission. The address bits below the page boundary pass through untranslated.

New mappings arrive on a refill port and go into the slot named by a rotating victim pointer. Two maintenance inputs drop mappings. One clears every slot. The other clears only the slots that translate a supplied address, and an instance parameter can remove that second function. An instruction-side instance would use only the full clear. Page-table walking, permission faults and domain checks are left to surrounding logic.

Each slot is a two-state machine, `SLOT_EMPTY` and `SLOT_LIVE`. The `load` transition (refill aimed at the slot) moves either state to `SLOT_LIVE`. The `kill` transition (full clear, or a single clear that matches the slot, with no refill into it in the same cycle) moves `SLOT_LIVE` to `SLOT_EMPTY`. The `hold` transition keeps the state in every other case.

Top module: `tlb_rr`

## Requirements
- R1: While reset is held and after its release, every slot is empty and every lookup misses. On a miss the physical address and all attribute outputs are zero.
- R2: A mapping written with size code 2'b10 (1 MB section) hits when VA[31:20] equals its stored virtual tag, and returns {stored PA[31:20], VA[19:0]}.
- R3: A mapping written with size code 2'b01 (64 KB large page) hits when VA[31:16] matches, and returns {stored PA[31:16], VA[15:0]}.
- R4: A mapping written with size code 2'b00 (4 KB small page) hits when VA[31:12] matches, and returns {stored PA[31:12], VA[11:0]}. Code 2'b11 behaves as a small page.
- R5: On a hit, the cacheable, bufferable and permission outputs equal the values written with the hitting mapping.
- R6: A refill writes the slot under the victim pointer. The pointer starts at 0 after reset, advances by one on each refill and wraps from the last slot to 0. The 33rd refill in a row therefore replaces the first of those refills.
- R7: Neither flush input moves the victim pointer.
- R8: A full clear empties every slot. A refill in the same cycle is kept.
- R9: A single clear empties the live slots whose size-dependent compare matches the supplied address and leaves every other slot intact. A refill in the same cycle is kept.
- R10: With FLUSH_ONE_EN set to 0, the single-clear input has no effect on any slot.
- R11: A lookup in the same cycle as a refill sees the contents from before the refill. The new mapping hits from the next cycle on.
- R12: When several live slots match a lookup, the lowest-indexed slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a live matching slot |
| lk_pa | output | 32 | Translated physical address, zero on miss |
| lk_cach | output | 1 | Cacheable attribute of the hit |
| lk_bufr | output | 1 | Bufferable attribute of the hit |
| lk_ap | output | 2 | Access permission of the hit |
| fill_en | input | 1 | Refill strobe |
| fill_va | input | 32 | Refill virtual address (bits 31:12 kept) |
| fill_pa | input | 32 | Refill physical address (bits 31:12 kept) |
| fill_size | input | 2 | Page size code: 00 small, 01 large, 10 section, 11 small |
| fill_cach | input | 1 | Refill cacheable bit |
| fill_bufr | input | 1 | Refill bufferable bit |
| fill_ap | input | 2 | Refill access permission |
| flush_all | input | 1 | Clear every slot |
| flush_one | input | 1 | Clear slots translating flush_va |
| flush_va | input | 32 | Address for the single clear |

## Verification
The bench builds two instances with the default 32 slots and feeds both the same stimulus. One instance has FLUSH_ONE_EN at 1 and the other at 0, so every single clear shows a selective drop on the first instance and no change on the second. Using the full 32 slots lets a run of 33 refills wrap the victim pointer, which makes rotation and its independence from flushes visible at the lookup port. Random refills draw from a narrow address pool with all four size codes. This produces overlapping mappings of different sizes and drives the lowest-index priority rule.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W     = 32;
    localparam int SMALL_SH = 12;
    localparam int LARGE_SH = 16;
    localparam int SECT_SH  = 20;
    localparam int TAG_W    = VA_W - SMALL_SH;

    typedef enum logic [1:0] {
        PG_SMALL = 2'b00,
        PG_LARGE = 2'b01,
        PG_SECT  = 2'b10,
        PG_RSVD  = 2'b11
    } pg_size_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_LIVE  = 1'b1
    } slot_st_e;

    typedef struct packed {
        logic       cach;
        logic       bufr;
        logic [1:0] ap;
    } tlb_attr_t;

    typedef struct packed {
        logic [TAG_W-1:0] vtag;
        logic [TAG_W-1:0] ptag;
        pg_size_e         size;
        tlb_attr_t        attr;
    } tlb_entry_t;

    function automatic logic tag_hit(input tlb_entry_t e, input logic [VA_W-1:0] va);
        logic r;
        unique case (e.size)
            PG_SECT:  r = (e.vtag[TAG_W-1:SECT_SH-SMALL_SH]  == va[VA_W-1:SECT_SH]);
            PG_LARGE: r = (e.vtag[TAG_W-1:LARGE_SH-SMALL_SH] == va[VA_W-1:LARGE_SH]);
            default:  r = (e.vtag == va[VA_W-1:SMALL_SH]);
        endcase
        return r;
    endfunction

    function automatic logic [VA_W-1:0] pa_form(input tlb_entry_t e, input logic [VA_W-1:0] va);
        logic [VA_W-1:0] r;
        unique case (e.size)
            PG_SECT:  r = {e.ptag[TAG_W-1:SECT_SH-SMALL_SH],  va[SECT_SH-1:0]};
            PG_LARGE: r = {e.ptag[TAG_W-1:LARGE_SH-SMALL_SH], va[LARGE_SH-1:0]};
            default:  r = {e.ptag, va[SMALL_SH-1:0]};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  tlb_entry_t       wr_ent,
    input  logic             clr_all,
    input  logic             fl_req,
    input  logic [VA_W-1:0]  fl_va,
    input  logic [VA_W-1:0]  lk_va,
    output logic             lk_match,
    output tlb_entry_t       ent
);

    slot_st_e   state_q, state_d;
    tlb_entry_t ent_q;
    logic       fl_match;
    logic       kill;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            ent_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wr) begin
                ent_q <= wr_ent;
            end
        end
    end

    // next state: load / kill / hold
    always_comb begin
        fl_match = (state_q == SLOT_LIVE) && tag_hit(ent_q, fl_va);
        kill     = clr_all || (fl_req && fl_match);
        state_d  = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (wr) state_d = SLOT_LIVE;
            end
            SLOT_LIVE: begin
                if (wr)        state_d = SLOT_LIVE;
                else if (kill) state_d = SLOT_EMPTY;
            end
        endcase
    end

    // outputs
    always_comb begin
        lk_match = (state_q == SLOT_LIVE) && tag_hit(ent_q, lk_va);
        ent      = ent_q;
    end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
    end

    assign idx = idx_q;

endmodule

// File: rtl/tlb_rr.sv
module tlb_rr
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES    = 32,
    parameter bit FLUSH_ONE_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] lk_va,
    output logic        lk_hit,
    output logic [31:0] lk_pa,
    output logic        lk_cach,
    output logic        lk_bufr,
    output logic [1:0]  lk_ap,
    input  logic        fill_en,
    input  logic [31:0] fill_va,
    input  logic [31:0] fill_pa,
    input  logic [1:0]  fill_size,
    input  logic        fill_cach,
    input  logic        fill_bufr,
    input  logic [1:0]  fill_ap,
    input  logic        flush_all,
    input  logic        flush_one,
    input  logic [31:0] flush_va
);

    localparam int IDX_W = $clog2(N_ENTRIES);

    logic [IDX_W-1:0]     victim_idx;
    logic [IDX_W-1:0]     hit_idx;
    logic [N_ENTRIES-1:0] match_vec;
    logic                 any_hit;
    logic                 fl_req;
    tlb_entry_t           new_ent;
    tlb_entry_t           ent_arr [N_ENTRIES];
    tlb_entry_t           sel;

    assign fl_req = FLUSH_ONE_EN && flush_one;

    always_comb begin
        new_ent.vtag      = fill_va[VA_W-1:SMALL_SH];
        new_ent.ptag      = fill_pa[VA_W-1:SMALL_SH];
        new_ent.size      = pg_size_e'(fill_size);
        new_ent.attr.cach = fill_cach;
        new_ent.attr.bufr = fill_bufr;
        new_ent.attr.ap   = fill_ap;
    end

    tlb_victim #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (fill_en),
        .idx   (victim_idx)
    );

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        tlb_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (fill_en && (victim_idx == IDX_W'(g))),
            .wr_ent   (new_ent),
            .clr_all  (flush_all),
            .fl_req   (fl_req),
            .fl_va    (flush_va),
            .lk_va    (lk_va),
            .lk_match (match_vec[g]),
            .ent      (ent_arr[g])
        );
    end

    tlb_pick #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .req (match_vec),
        .any (any_hit),
        .idx (hit_idx)
    );

    always_comb begin
        sel     = ent_arr[hit_idx];
        lk_hit  = any_hit;
        lk_pa   = any_hit ? pa_form(sel, lk_va) : '0;
        lk_cach = any_hit && sel.attr.cach;
        lk_bufr = any_hit && sel.attr.bufr;
        lk_ap   = any_hit ? sel.attr.ap : 2'b00;
    end

endmodule

// File: rtl/tlb_rr_chk.sv
module tlb_rr_chk #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      lk_va,
    input logic             lk_hit,
    input logic [31:0]      lk_pa,
    input logic             fill_en,
    input logic [31:0]      fill_va,
    input logic             flush_all,
    input logic [IDX_W-1:0] victim_idx
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit);

    // R1
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pa == 32'h0));

    // R4
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));

    // R6
    victim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (victim_idx == (($past(victim_idx) == IDX_W'(N - 1)) ? '0 : $past(victim_idx) + 1'b1)));

    // R7
    victim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> $stable(victim_idx));

    // R8
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && !fill_en) |=> !lk_hit);

    // R11
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> ((lk_va != $past(fill_va)) || lk_hit));

endmodule

bind tlb_rr tlb_rr_chk #(.N(N_ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_va      (lk_va),
    .lk_hit     (lk_hit),
    .lk_pa      (lk_pa),
    .fill_en    (fill_en),
    .fill_va    (fill_va),
    .flush_all  (flush_all),
    .victim_idx (victim_idx)
);

// File: tb/tlb_rr_bench.sv
`timescale 1ns/1ps
module tlb_rr_bench;

    localparam int NE = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_va = '0;
    logic        fill_en = 1'b0;
    logic [31:0] fill_va = '0, fill_pa = '0;
    logic [1:0]  fill_size = '0;
    logic        fill_cach = 1'b0, fill_bufr = 1'b0;
    logic [1:0]  fill_ap = '0;
    logic        flush_all = 1'b0, flush_one = 1'b0;
    logic [31:0] flush_va = '0;

    logic        a_hit, b_hit, a_c, b_c, a_b, b_b;
    logic [31:0] a_pa, b_pa;
    logic [1:0]  a_ap, b_ap;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tlb_rr u_tlb_rr (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va),
        .lk_hit(a_hit), .lk_pa(a_pa), .lk_cach(a_c), .lk_bufr(a_b), .lk_ap(a_ap),
        .fill_en(fill_en), .fill_va(fill_va), .fill_pa(fill_pa), .fill_size(fill_size),
        .fill_cach(fill_cach), .fill_bufr(fill_bufr), .fill_ap(fill_ap),
        .flush_all(flush_all), .flush_one(flush_one), .flush_va(flush_va)
    );

    tlb_rr #(.FLUSH_ONE_EN(1'b0)) u_tlb_rr_nf (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va),
        .lk_hit(b_hit), .lk_pa(b_pa), .lk_cach(b_c), .lk_bufr(b_b), .lk_ap(b_ap),
        .fill_en(fill_en), .fill_va(fill_va), .fill_pa(fill_pa), .fill_size(fill_size),
        .fill_cach(fill_cach), .fill_bufr(fill_bufr), .fill_ap(fill_ap),
        .flush_all(flush_all), .flush_one(flush_one), .flush_va(flush_va)
    );

    // reference state from the requirements
    logic        mv  [NE];
    logic        mvn [NE];
    logic [19:0] mvt [NE];
    logic [19:0] mpt [NE];
    logic [1:0]  msz [NE];
    logic [3:0]  mat [NE];
    int          mvic = 0;

    function automatic bit mhit(input int i, input logic [31:0] va);
        if (msz[i] == 2'b10) return mvt[i][19:8] == va[31:20];
        if (msz[i] == 2'b01) return mvt[i][19:4] == va[31:16];
        return mvt[i] == va[31:12];
    endfunction

    function automatic logic [36:0] mexp(input bit nf, input logic [31:0] va);
        for (int i = 0; i < NE; i++) begin
            if ((nf ? mvn[i] : mv[i]) && mhit(i, va)) begin
                logic [31:0] pa;
                if (msz[i] == 2'b10)      pa = {mpt[i][19:8], va[19:0]};
                else if (msz[i] == 2'b01) pa = {mpt[i][19:4], va[15:0]};
                else                      pa = {mpt[i], va[11:0]};
                return {1'b1, pa, mat[i]};
            end
        end
        return '0;
    endfunction

    function automatic void mapply(input bit f, input logic [31:0] va, input logic [31:0] pa,
                                   input logic [1:0] sz, input logic [3:0] at,
                                   input bit fa, input bit fo, input logic [31:0] fva);
        if (fa) begin
            for (int i = 0; i < NE; i++) begin mv[i] = 1'b0; mvn[i] = 1'b0; end
        end
        if (fo) begin
            for (int i = 0; i < NE; i++) if (mv[i] && mhit(i, fva)) mv[i] = 1'b0;
        end
        if (f) begin
            mvt[mvic] = va[31:12]; mpt[mvic] = pa[31:12];
            msz[mvic] = sz; mat[mvic] = at;
            mv[mvic] = 1'b1; mvn[mvic] = 1'b1;
            mvic = (mvic + 1) % NE;
        end
    endfunction

    task automatic cmp(input string rq);
        logic [36:0] ea, eb, ga, gb;
        ea = mexp(1'b0, lk_va);
        eb = mexp(1'b1, lk_va);
        ga = {a_hit, a_pa, a_c, a_b, a_ap};
        gb = {b_hit, b_pa, b_c, b_b, b_ap};
        n_chk++;
        if (ga !== ea || gb !== eb) begin
            n_bad++;
            $display("FAIL %s va=%h actual a=%h b=%h expected a=%h b=%h", rq, lk_va, ga, gb, ea, eb);
        end
    endtask

    task automatic look(input logic [31:0] va, input string rq);
        @(negedge clk);
        lk_va = va;
        #1;
        cmp(rq);
    endtask

    // direct hit/miss check against a value derived by hand
    task automatic want(input logic [31:0] va, input bit h, input logic [31:0] pa, input string rq);
        @(negedge clk);
        lk_va = va;
        #1;
        n_chk++;
        if (a_hit !== h || (h && a_pa !== pa)) begin
            n_bad++;
            $display("FAIL %s va=%h actual hit=%b pa=%h expected hit=%b pa=%h", rq, va, a_hit, a_pa, h, pa);
        end
    endtask

    task automatic op(input bit f, input logic [31:0] va, input logic [31:0] pa,
                      input logic [1:0] sz, input logic [3:0] at,
                      input bit fa, input bit fo, input logic [31:0] fva);
        @(negedge clk);
        fill_en = f; fill_va = va; fill_pa = pa; fill_size = sz;
        {fill_cach, fill_bufr, fill_ap} = at;
        flush_all = fa; flush_one = fo; flush_va = fva;
        @(posedge clk);
        #1;
        fill_en = 1'b0; flush_all = 1'b0; flush_one = 1'b0;
        mapply(f, va, pa, sz, at, fa, fo, fva);
    endtask

    task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz, input logic [3:0] at);
        op(1'b1, va, pa, sz, at, 1'b0, 1'b0, '0);
    endtask

    function automatic logic [31:0] pool_va();
        return {4'h3, 4'($urandom % 3), 4'($urandom % 3), 4'($urandom % 3), 4'($urandom % 3), 12'($urandom)};
    endfunction

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] batch [33];
        void'($urandom(32'd7341));
        for (int i = 0; i < NE; i++) begin mv[i] = 0; mvn[i] = 0; mvt[i] = 0; mpt[i] = 0; msz[i] = 0; mat[i] = 0; end
        repeat (3) @(negedge clk);
        #1;
        cmp("R1 in reset");
        rst_n = 1'b1;
        look(32'h0000_0000, "R1");
        look(32'h1234_5678, "R1");

        // R2 section
        fill(32'h1234_5678, 32'hABC0_0000, 2'b10, 4'b1011);
        want(32'h123F_FFFF, 1'b1, 32'hABCF_FFFF, "R2");
        want(32'h1240_0000, 1'b0, 32'h0, "R2");
        look(32'h1230_0001, "R5");
        // R3 large page
        fill(32'h5678_0000, 32'h9ABC_0000, 2'b01, 4'b0110);
        want(32'h5678_FFF0, 1'b1, 32'h9ABC_FFF0, "R3");
        want(32'h5679_0000, 1'b0, 32'h0, "R3");
        // R4 small page
        fill(32'h7000_A000, 32'h0001_B000, 2'b00, 4'b1100);
        want(32'h7000_AFFF, 1'b1, 32'h0001_BFFF, "R4");
        want(32'h7000_B000, 1'b0, 32'h0, "R4");
        look(32'h7000_A123, "R5");
        // R12 overlap: lower slot wins either way
        fill(32'h4000_0000, 32'h1110_0000, 2'b10, 4'b0001);
        fill(32'h4000_5000, 32'h2220_0000, 2'b00, 4'b0010);
        want(32'h4000_5ABC, 1'b1, 32'h1110_5ABC, "R12");
        fill(32'h5000_6000, 32'h3330_0000, 2'b00, 4'b0011);
        fill(32'h5000_0000, 32'h4440_0000, 2'b10, 4'b0100);
        want(32'h5000_6123, 1'b1, 32'h3330_0123, "R12");
        want(32'h5000_7000, 1'b1, 32'h4440_7000, "R12");
        // R9 / R10 single clear
        op(1'b0, '0, '0, 2'b00, 4'b0, 1'b0, 1'b1, 32'h4000_5000);
        want(32'h4000_5ABC, 1'b0, 32'h0, "R9");
        look(32'h4000_5ABC, "R10");
        want(32'h1234_5678, 1'b1, 32'hABC4_5678, "R9");
        // R11 same-cycle refill and lookup
        @(negedge clk);
        fill_en = 1'b1; fill_va = 32'h6600_1000; fill_pa = 32'h7700_2000; fill_size = 2'b00;
        {fill_cach, fill_bufr, fill_ap} = 4'b1111;
        lk_va = 32'h6600_1444;
        #1;
        cmp("R11 before");
        @(posedge clk);
        #1;
        fill_en = 1'b0;
        mapply(1'b1, 32'h6600_1000, 32'h7700_2000, 2'b00, 4'b1111, 1'b0, 1'b0, '0);
        #1;
        cmp("R11 after");
        // R8 full clear, then clear plus refill together
        op(1'b0, '0, '0, 2'b00, 4'b0, 1'b1, 1'b0, '0);
        want(32'h1234_5678, 1'b0, 32'h0, "R8");
        look(32'h5678_1234, "R8");
        op(1'b1, 32'h2100_0000, 32'h3100_0000, 2'b10, 4'b0101, 1'b1, 1'b0, '0);
        want(32'h2100_0042, 1'b1, 32'h3100_0042, "R8");
        // R6 wrap: 33 refills in a row evict the first
        for (int i = 0; i < 33; i++) begin
            batch[i] = 32'h8000_0000 + (i << 12);
            fill(batch[i], 32'h0900_0000 + (i << 12), 2'b00, 4'(i));
        end
        want(batch[0], 1'b0, 32'h0, "R6");
        want(batch[1], 1'b1, 32'h0900_1000, "R6");
        want(batch[32], 1'b1, 32'h0902_0000, "R6");
        // R7 flush leaves the pointer: next refill evicts batch[1]
        op(1'b0, '0, '0, 2'b00, 4'b0, 1'b0, 1'b1, batch[10]);
        fill(32'h9900_0000, 32'h0AA0_0000, 2'b00, 4'b1001);
        want(batch[1], 1'b0, 32'h0, "R7");
        want(batch[2], 1'b1, 32'h0900_2000, "R7");
        want(32'h9900_0010, 1'b1, 32'h0AA0_0010, "R7");
        look(batch[10], "R10");

        // random phase
        op(1'b0, '0, '0, 2'b00, 4'b0, 1'b1, 1'b0, '0);
        for (int k = 0; k < 800; k++) begin
            int r;
            r = int'($urandom % 20);
            if (r < 8) begin
                fill(pool_va(), $urandom, 2'($urandom), 4'($urandom));
            end else if (r < 17) begin
                look(pool_va(), "R2 R3 R4 R5 R12 random");
            end else if (r < 19) begin
                op(1'b0, '0, '0, 2'b00, 4'b0, 1'b0, 1'b1, pool_va());
                look(pool_va(), "R9 R10 random");
            end else begin
                op($urandom % 2 == 0, pool_va(), $urandom, 2'($urandom), 4'($urandom), 1'b1, 1'b0, '0);
                look(pool_va(), "R8 random");
            end
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule